// File: doc/BRIEF.md
# Text Cell Pixel Slice Generator

This block produces one horizontal slice of a character cell for a text display. A character code and a scanline index come in with a load strobe. The block turns the scanline into a stored-row index, and builds a 13-bit glyph memory address from that row index and the character code. It takes the byte that the external glyph memory returns one cycle later and applies the reverse-video and underline attributes to it. It then sends the eight pixels out one per clock with a valid flag.

The stored-row index is the scanline rotated back by one. The first scanline of a cell therefore shows the last stored row, and each later scanline shows the stored row just above it. The number of scanlines per cell is an input at run time. The glyph memory, the display timing and the cursor are outside the block.

Issuing a load every eight cycles gives a pixel stream with no gaps. The output is a small state machine with two states. `SH_IDLE` moves to `SH_RUN` on a *fill*, which happens when fetched data arrives. In `SH_RUN`, each *step* shifts out one pixel. A *refill* (new data arriving while pixels are still being sent) restarts the slice. A *drain* returns the machine to `SH_IDLE` after the eighth pixel when no new data has arrived.

Top module: `glyph_slice_gen`

## Requirements
- R1: A synchronous active-high reset, including one applied while pixels are being sent, leaves pixel_valid low and pixel_out low in the first cycle after the reset edge.
- R2: The stored-row index depends on the scanline as follows. Scanline 0 maps to rows_per_cell minus 1, and any other scanline y maps to y minus 1. rows_per_cell must be at least 1, and the scanline must be below rows_per_cell.
- R3: rom_addr is combinational from the current inputs and is laid out as follows. Bits 6..0 carry char_code[6:0], bits 10..7 carry stored-row bits 3..0, bit 11 carries char_code[7], and bit 12 carries stored-row bit 4.
- R4: When reverse_en is high at load, all eight fetched bits are inverted.
- R5: When underline_en is high at load and the scanline equals rows_per_cell minus 1, the slice is all ones whatever the fetched byte and reverse_en. On any other scanline, underline_en has no effect.
- R6: rom_data is sampled on the clock edge after the load edge. The first pixel is therefore valid in the second cycle after the load cycle. Pixels come out one per clock, data bit 0 first (the leftmost pixel) and bit 7 last (the rightmost).
- R7: After one load, pixel_valid is high for exactly eight consecutive cycles and then goes low.
- R8: A load issued eight cycles after the previous one makes the next slice follow with no idle cycle, and both slices keep their correct contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Starts a slice using the current code, scanline and attributes |
| char_code | input | 8 | Character code |
| row_idx | input | 5 | Scanline index within the cell |
| rows_per_cell | input | 5 | Scanlines per cell, 1 to 31 |
| reverse_en | input | 1 | Inverts the slice |
| underline_en | input | 1 | Forces the last scanline of the cell to all ones |
| rom_addr | output | 13 | Glyph memory address |
| rom_data | input | 8 | Glyph memory data, returned one cycle after the address |
| pixel_out | output | 1 | Serial pixel, leftmost first |
| pixel_valid | output | 1 | High while pixel_out carries a pixel |

## Verification
The assertions assume the following about the inputs:
- rows_per_cell is never zero.
- row_idx stays below rows_per_cell.
- The glyph memory returns its data exactly one cycle after the address.

The underline and stored-row checks rely on the first two of these to define what the last row is. The stream checks rely on the third for pixel timing. The bench stays within these limits: it loops over every rows_per_cell from 1 to 31 and every scanline below it, and models the memory as a register clocked from rom_addr. Every slice is tried with each combination of reverse and underline, and with the top character bit both clear and set.

// File: rtl/glyph_slice_pkg.sv
package glyph_slice_pkg;

    // Cell geometry and code widths
    parameter int PIX_W  = 8;   // pixels per slice
    parameter int CHAR_W = 8;   // character code width
    parameter int ROW_W  = 5;   // scanline index width

    // Split points of the interleaved glyph address
    parameter int CHAR_LO_BITS = 7;  // code bits placed at the bottom
    parameter int ROW_LO_BITS  = 4;  // row bits placed above them

    localparam int ADDR_W = CHAR_W + ROW_W;
    localparam int CNT_W  = $clog2(PIX_W);

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_RUN  = 1'b1
    } shift_state_e;

    typedef struct packed {
        logic invert;   // reverse video requested
        logic ul_hit;   // underline requested on the cell's last scanline
    } slice_attr_t;

endpackage

// File: rtl/glyph_row_remap.sv
module glyph_row_remap
    import glyph_slice_pkg::*;
(
    input  logic [ROW_W-1:0] scan_row,
    input  logic [ROW_W-1:0] cell_rows,
    output logic [ROW_W-1:0] stored_row,
    output logic             last_scan
);

    localparam logic [ROW_W-1:0] ONE = ROW_W'(1);

    logic [ROW_W-1:0] last_row;

    always_comb begin
        last_row = cell_rows - ONE;
        // Rotate back by one: the first scanline wraps to the last stored row
        if (scan_row == '0) begin
            stored_row = last_row;
        end else begin
            stored_row = scan_row - ONE;
        end
        // Underline test uses the raw scanline, not the rotated one
        last_scan = (scan_row == last_row);
    end

endmodule

// File: rtl/glyph_addr_map.sv
module glyph_addr_map
    import glyph_slice_pkg::*;
(
    input  logic [CHAR_W-1:0] code,
    input  logic [ROW_W-1:0]  row,
    output logic [ADDR_W-1:0] addr
);

    localparam int CHAR_HI_BITS = CHAR_W - CHAR_LO_BITS;
    localparam int ROW_HI_BITS  = ROW_W - ROW_LO_BITS;

    logic [CHAR_LO_BITS-1:0] code_lo;
    logic [CHAR_HI_BITS-1:0] code_hi;
    logic [ROW_LO_BITS-1:0]  row_lo;
    logic [ROW_HI_BITS-1:0]  row_hi;

    always_comb begin
        code_lo = code[CHAR_LO_BITS-1:0];
        code_hi = code[CHAR_W-1:CHAR_LO_BITS];
        row_lo  = row[ROW_LO_BITS-1:0];
        row_hi  = row[ROW_W-1:ROW_LO_BITS];
        // From the top: high row bits, high code bits, low row bits, low code bits
        addr    = {row_hi, code_hi, row_lo, code_lo};
    end

endmodule

// File: rtl/glyph_attr_stage.sv
module glyph_attr_stage
    import glyph_slice_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             reverse_en,
    input  logic             underline_en,
    input  logic             last_scan,
    input  logic [PIX_W-1:0] rom_data,
    output logic             fill,
    output logic [PIX_W-1:0] slice
);

    slice_attr_t attr_q;
    logic        pend_q;

    // Attributes travel one stage to meet the registered memory data
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            attr_q <= '0;
        end else begin
            pend_q <= load;
            if (load) begin
                attr_q.invert <= reverse_en;
                attr_q.ul_hit <= underline_en & last_scan;
            end
        end
    end

    always_comb begin
        fill = pend_q;
        if (attr_q.ul_hit) begin
            slice = '1;                 // underline wins over reverse
        end else if (attr_q.invert) begin
            slice = ~rom_data;
        end else begin
            slice = rom_data;
        end
    end

endmodule

// File: rtl/glyph_pixel_shifter.sv
module glyph_pixel_shifter
    import glyph_slice_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fill,
    input  logic [PIX_W-1:0] slice,
    output logic             pixel_out,
    output logic             pixel_valid
);

    localparam logic [CNT_W-1:0] LAST_PIX = CNT_W'(PIX_W - 1);

    shift_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PIX_W-1:0] sh_q, sh_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SH_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
        end
    end

    // Transitions: fill, step, refill, drain
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sh_d    = sh_q;
        unique case (state_q)
            SH_IDLE: begin
                if (fill) begin
                    state_d = SH_RUN;
                    cnt_d   = '0;
                    sh_d    = slice;
                end
            end
            SH_RUN: begin
                if (fill) begin
                    state_d = SH_RUN;
                    cnt_d   = '0;
                    sh_d    = slice;
                end else if (cnt_q == LAST_PIX) begin
                    state_d = SH_IDLE;
                    cnt_d   = '0;
                    sh_d    = '0;
                end else begin
                    cnt_d   = cnt_q + CNT_W'(1);
                    sh_d    = {1'b0, sh_q[PIX_W-1:1]};
                end
            end
            default: begin
                state_d = SH_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        pixel_valid = (state_q == SH_RUN);
        pixel_out   = pixel_valid & sh_q[0];
    end

endmodule

// File: rtl/glyph_slice_gen.sv
module glyph_slice_gen
    import glyph_slice_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CHAR_W-1:0] char_code,
    input  logic [ROW_W-1:0]  row_idx,
    input  logic [ROW_W-1:0]  rows_per_cell,
    input  logic              reverse_en,
    input  logic              underline_en,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [PIX_W-1:0]  rom_data,
    output logic              pixel_out,
    output logic              pixel_valid
);

    logic [ROW_W-1:0] stored_row;
    logic             last_scan;
    logic             fill;
    logic [PIX_W-1:0] slice;

    glyph_row_remap u_remap (
        .scan_row   (row_idx),
        .cell_rows  (rows_per_cell),
        .stored_row (stored_row),
        .last_scan  (last_scan)
    );

    glyph_addr_map u_addr (
        .code (char_code),
        .row  (stored_row),
        .addr (rom_addr)
    );

    glyph_attr_stage u_attr (
        .clk          (clk),
        .rst          (rst),
        .load         (load),
        .reverse_en   (reverse_en),
        .underline_en (underline_en),
        .last_scan    (last_scan),
        .rom_data     (rom_data),
        .fill         (fill),
        .slice        (slice)
    );

    glyph_pixel_shifter u_shift (
        .clk         (clk),
        .rst         (rst),
        .fill        (fill),
        .slice       (slice),
        .pixel_out   (pixel_out),
        .pixel_valid (pixel_valid)
    );

endmodule

// File: rtl/glyph_slice_gen_chk.sv
module glyph_slice_gen_chk
    import glyph_slice_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              load,
    input logic [CHAR_W-1:0] char_code,
    input logic [ROW_W-1:0]  row_idx,
    input logic [ROW_W-1:0]  rows_per_cell,
    input logic              underline_en,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              pixel_out,
    input logic              pixel_valid
);

    localparam int AGE_W = CNT_W + 1;
    localparam logic [AGE_W-1:0] AGE_MAX = '1;
    localparam logic [ROW_W-1:0] ONE     = ROW_W'(1);

    logic             l1_q, l2_q;
    logic             uh1_q, uh2_q, hold_q, hold_now;
    logic [AGE_W-1:0] age_q, age_now;
    logic [ROW_W-1:0] addr_row;

    assign addr_row = {rom_addr[ADDR_W-1], rom_addr[CHAR_LO_BITS +: ROW_LO_BITS]};
    assign age_now  = l2_q ? '0 : age_q;
    assign hold_now = l2_q ? uh2_q : hold_q;

    // Independent model of the load-to-first-pixel latency
    always_ff @(posedge clk) begin
        if (rst) begin
            l1_q   <= 1'b0;
            l2_q   <= 1'b0;
            uh1_q  <= 1'b0;
            uh2_q  <= 1'b0;
            hold_q <= 1'b0;
            age_q  <= AGE_MAX;
        end else begin
            l1_q   <= load;
            l2_q   <= l1_q;
            uh1_q  <= load & underline_en & (row_idx == rows_per_cell - ONE);
            uh2_q  <= uh1_q;
            hold_q <= hold_now;
            age_q  <= (age_now == AGE_MAX) ? AGE_MAX : age_now + AGE_W'(1);
        end
    end

    a_r2_first_row_wraps: assert property (@(posedge clk) disable iff (rst)
        (load && row_idx == '0 && rows_per_cell != '0) |-> addr_row == rows_per_cell - ONE);

    a_r2_later_row_steps: assert property (@(posedge clk) disable iff (rst)
        (load && row_idx != '0) |-> addr_row == row_idx - ONE);

    a_r3_code_bits_placed: assert property (@(posedge clk) disable iff (rst)
        load |-> (rom_addr[CHAR_LO_BITS-1:0] == char_code[CHAR_LO_BITS-1:0]
                  && rom_addr[CHAR_LO_BITS+ROW_LO_BITS] == char_code[CHAR_W-1]));

    a_r5_underline_ones: assert property (@(posedge clk) disable iff (rst)
        (pixel_valid && hold_now) |-> pixel_out);

    a_r6_first_pixel_delay: assert property (@(posedge clk) disable iff (rst)
        load |-> ##2 pixel_valid);

    a_r7_valid_window: assert property (@(posedge clk) disable iff (rst)
        pixel_valid == (age_now < AGE_W'(PIX_W)));

endmodule

bind glyph_slice_gen glyph_slice_gen_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .load          (load),
    .char_code     (char_code),
    .row_idx       (row_idx),
    .rows_per_cell (rows_per_cell),
    .underline_en  (underline_en),
    .rom_addr      (rom_addr),
    .pixel_out     (pixel_out),
    .pixel_valid   (pixel_valid)
);

// File: tb/glyph_slice_gen_bench.sv
`timescale 1ns/1ps
module glyph_slice_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [7:0]  char_code = '0;
    logic [4:0]  row_idx = '0;
    logic [4:0]  rows_per_cell = 5'd1;
    logic        reverse_en = 1'b0;
    logic        underline_en = 1'b0;
    logic [12:0] rom_addr;
    logic [7:0]  rom_data = '0;
    logic        pixel_out;
    logic        pixel_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    glyph_slice_gen u_glyph_slice_gen (
        .clk           (clk),
        .rst           (rst),
        .load          (load),
        .char_code     (char_code),
        .row_idx       (row_idx),
        .rows_per_cell (rows_per_cell),
        .reverse_en    (reverse_en),
        .underline_en  (underline_en),
        .rom_addr      (rom_addr),
        .rom_data      (rom_data),
        .pixel_out     (pixel_out),
        .pixel_valid   (pixel_valid)
    );

    function automatic logic [7:0] rom_fn(input logic [12:0] a);
        return 8'((a * 13'd29) ^ (a >> 5) ^ 13'h5a);
    endfunction

    // Glyph memory model: registered read
    always_ff @(posedge clk) rom_data <= rom_fn(rom_addr);

    function automatic logic [12:0] exp_addr(input logic [7:0] ch, input logic [4:0] row,
                                             input logic [4:0] rows);
        logic [4:0] rr;
        rr = (row == 5'd0) ? rows - 5'd1 : row - 5'd1;
        return 13'(ch[6:0]) + 13'(rr[3:0]) * 13'd128 + 13'(ch[7]) * 13'd2048
             + 13'(rr[4]) * 13'd4096;
    endfunction

    function automatic logic [7:0] exp_slice(input logic [7:0] ch, input logic [4:0] row,
                                             input logic [4:0] rows, input logic rv,
                                             input logic ul);
        logic [7:0] b;
        b = rom_fn(exp_addr(ch, row, rows));
        if (rv) b = ~b;
        if (ul && row == rows - 5'd1) b = 8'hff;
        return b;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic drive(input logic [7:0] ch, input logic [4:0] row, input logic [4:0] rows,
                         input logic rv, input logic ul);
        char_code = ch; row_idx = row; rows_per_cell = rows;
        reverse_en = rv; underline_en = ul; load = 1'b1;
    endtask

    task automatic run_slice(input logic [7:0] ch, input logic [4:0] row, input logic [4:0] rows,
                             input logic rv, input logic ul);
        logic [12:0] ea;
        logic [7:0]  eb, got;
        bit          vok;
        string       tag;
        ea = exp_addr(ch, row, rows);
        eb = exp_slice(ch, row, rows, rv, ul);
        @(negedge clk);
        drive(ch, row, rows, rv, ul);
        #1;
        check(rom_addr === ea, "R2 R3 address", int'(rom_addr), int'(ea));
        @(negedge clk);
        load = 1'b0;
        vok = (pixel_valid === 1'b0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            got[i] = pixel_out;
            vok &= (pixel_valid === 1'b1);
        end
        @(negedge clk);
        vok &= (pixel_valid === 1'b0);
        if (ul && row == rows - 5'd1) tag = "R5 underline";
        else if (rv)                  tag = "R4 reverse";
        else                          tag = "R6 pixel order";
        check(got === eb, tag, int'(got), int'(eb));
        check(vok, "R7 valid window", int'(vok), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(pixel_valid === 1'b0 && pixel_out === 1'b0, "R1 reset idle",
              int'({pixel_valid, pixel_out}), 0);
        rst = 1'b0;

        // Sweep all cell heights, all scanlines, all attribute pairs
        for (int rows = 1; rows < 32; rows++) begin
            for (int row = 0; row < rows; row++) begin
                for (int m = 0; m < 4; m++) begin
                    logic [7:0] ch;
                    ch = 8'(rows * 7 + row * 29 + m * 61);
                    run_slice(ch, 5'(row), 5'(rows), m[0], m[1]);
                    run_slice(ch ^ 8'h80, 5'(row), 5'(rows), m[0], m[1]);
                end
            end
        end

        // R8: back-to-back slices with no idle cycle
        begin
            logic [7:0] ea_b, eb_b, ga, gb;
            bit gapless;
            ea_b = exp_slice(8'h41, 5'd3, 5'd12, 1'b0, 1'b0);
            eb_b = exp_slice(8'hc2, 5'd0, 5'd12, 1'b1, 1'b0);
            gapless = 1;
            @(negedge clk);
            drive(8'h41, 5'd3, 5'd12, 1'b0, 1'b0);
            @(negedge clk);
            load = 1'b0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                ga[i] = pixel_out;
                gapless &= (pixel_valid === 1'b1);
                if (i == 6) drive(8'hc2, 5'd0, 5'd12, 1'b1, 1'b0);
                if (i == 7) load = 1'b0;
            end
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                gb[i] = pixel_out;
                gapless &= (pixel_valid === 1'b1);
            end
            check(gapless, "R8 gapless stream", int'(gapless), 1);
            check({ga, gb} === {ea_b, eb_b}, "R8 slice contents",
                  int'({ga, gb}), int'({ea_b, eb_b}));
        end

        // R1: reset in the middle of a slice
        @(negedge clk);
        drive(8'h13, 5'd2, 5'd9, 1'b1, 1'b0);
        @(negedge clk);
        load = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(pixel_valid === 1'b0 && pixel_out === 1'b0, "R1 mid-slice reset",
              int'({pixel_valid, pixel_out}), 0);
        rst = 1'b0;
        run_slice(8'h7f, 5'd0, 5'd16, 1'b0, 1'b1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule